// File: doc/BRIEF.md
# Aligned Pre-image Key and Read-Offset Unit

This unit moves short byte runs between one 64-bit big-endian memory word and two pieces of held state: a 32-byte key register and a read-offset counter. A write transfer pulls bytes out of the supplied memory word and appends them to the low end of the key, pushing older bytes out of the high end, and it rewinds the offset to zero. A read transfer takes bytes from a supplied data chunk, which holds the 8 bytes of the data stream starting at the current offset, and drops them into the memory word. It then moves the offset forward by the number of bytes placed. The lookup that produces the chunk and its total length is done outside the block.

Every transfer is clipped twice. It is limited to 8 bytes, and it is limited so that it cannot run past the end of the aligned 8-byte word that holds its start address. A read is also limited to the data bytes that remain after the offset. A read whose offset already lies beyond the data length is refused and reported through an error flag.

Requests arrive on a valid/ready port and results leave on a valid/ready port. The request side is back-pressured only by a result that has not been taken: `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays frozen while it waits. The key and the offset are plain outputs. They change on the clock edge that accepts a request, and the matching result appears one cycle later.

Top module: `pik_unit`

## Requirements
- R1: The requested count is limited to 8. Any request above 8 is treated as 8.
- R2: The effective count `rsp_count` never exceeds 8 minus `req_lane`, where `req_lane` is the start address modulo 8. An aligned request for 3 bytes moves exactly 3 bytes.
- R3: On a read, the effective count is also limited to the data length minus the current offset.
- R4: A write of n bytes shifts the key left by n bytes and places the n moved memory bytes in the low n bytes of the key, in address order. The byte with the lowest address ends up most significant. Bytes shifted past byte 31 are lost.
- R5: A write sets the offset to 0. It returns the memory word unchanged, with the error flag low.
- R6: A read that is not refused adds the effective count to the offset and leaves the key unchanged.
- R7: A read whose offset is greater than the data length raises `rsp_error`, reports a count of 0, returns the memory word unchanged, and leaves both the offset and the key unchanged. An offset equal to the length is not an error.
- R8: In the word returned by a read, memory lanes `req_lane` through `req_lane+n-1` hold chunk bytes 0 through n-1. Every other lane keeps its byte from the memory word. Byte lane k occupies bits [63-8k:56-8k], and chunk byte 0 occupies bits [63:56].
- R9: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, all result outputs hold their values.
- R10: After reset, the key is 0, the offset is 0, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_read | input | 1 | 1 = read transfer (chunk into memory), 0 = write transfer (memory into key) |
| req_lane | input | 3 | Start address modulo 8 |
| req_count | input | 64 | Requested byte count |
| req_mem_word | input | 64 | Memory word that holds the start address |
| req_chunk | input | 64 | Data bytes at the current offset, first byte in bits [63:56] |
| req_data_len | input | 64 | Total length of the data stream in bytes |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_count | output | 4 | Effective byte count, 0 to 8 |
| rsp_word | output | 64 | Merged memory word (reads) or unchanged word (writes, refused reads) |
| rsp_error | output | 1 | Read refused because the offset exceeds the data length |
| key | output | 256 | Key register |
| offset | output | 64 | Read offset |

## Verification
Two functions of the block can fall in the same cycle: draining a finished result and accepting the next request, since `req_ready` is raised by `rsp_ready` while `rsp_valid` is still high. The bench provokes this by issuing requests back to back while a pseudo-random pattern drives `rsp_ready`. Long stalls and same-edge drain-and-accept cycles are therefore mixed. The scoreboard checks that the results come out in request order, each with its own clipped count and merged word, and the key and offset are compared after every accepting edge. This shows that a result waiting under back-pressure is never overwritten or duplicated by the request taken on the edge that releases it.

// File: rtl/pik_pkg.sv
package pik_pkg;

  // Direction of one transfer
  typedef enum logic {
    XFER_TO_KEY  = 1'b0,   // memory bytes appended to key
    XFER_TO_MEM  = 1'b1    // chunk bytes merged into memory word
  } xfer_dir_e;

  // Default geometry shared by the unit and its bench
  localparam int unsigned PIK_WORD_BYTES = 8;
  localparam int unsigned PIK_KEY_BYTES  = 32;
  localparam int unsigned PIK_LEN_W      = 64;

endpackage

// File: rtl/pik_clip.sv
// Computes the effective byte count of one transfer.
module pik_clip #(
  parameter  int unsigned WORD_BYTES = 8,
  parameter  int unsigned LEN_W      = 64,
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES),
  localparam int unsigned CNT_W      = $clog2(WORD_BYTES + 1)
) (
  input  logic [LANE_W-1:0] lane,
  input  logic [LEN_W-1:0]  req_count,
  input  logic              is_read,
  input  logic [LEN_W-1:0]  cur_offset,
  input  logic [LEN_W-1:0]  data_len,
  output logic [CNT_W-1:0]  eff,
  output logic              overrun
);

  logic [CNT_W-1:0] room;
  logic [CNT_W-1:0] capped;
  logic [CNT_W-1:0] fit;
  logic [LEN_W-1:0] remain;

  always_comb begin
    // bytes left in the aligned word from the start lane onward
    room   = CNT_W'(WORD_BYTES) - CNT_W'(lane);
    capped = (req_count > LEN_W'(WORD_BYTES)) ? CNT_W'(WORD_BYTES)
                                              : CNT_W'(req_count);
    fit    = (capped < room) ? capped : room;

    overrun = is_read && (cur_offset > data_len);
    remain  = data_len - cur_offset;

    eff = fit;
    if (overrun) begin
      eff = '0;
    end else if (is_read && (remain < LEN_W'(fit))) begin
      eff = CNT_W'(remain);
    end
  end

endmodule

// File: rtl/pik_lanes.sv
// Byte-lane steering: merges chunk bytes into the memory word and
// gathers memory bytes to the top of a word for the key path.
module pik_lanes #(
  parameter  int unsigned WORD_BYTES = 8,
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES),
  localparam int unsigned CNT_W      = $clog2(WORD_BYTES + 1),
  localparam int unsigned WORD_W     = 8 * WORD_BYTES,
  localparam int unsigned SUM_W      = CNT_W + 1
) (
  input  logic [LANE_W-1:0] lane,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] chunk,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] gathered
);

  logic [WORD_W-1:0] aligned_chunk;
  logic [SUM_W-1:0]  win_lo;
  logic [SUM_W-1:0]  win_hi;

  // chunk byte 0 lands on lane 'lane'
  assign aligned_chunk = chunk >> {lane, 3'b000};
  // memory byte at 'lane' moves to the most significant lane
  assign gathered      = mem_word << {lane, 3'b000};

  assign win_lo = SUM_W'(lane);
  assign win_hi = SUM_W'(lane) + SUM_W'(count);

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    localparam int unsigned TOP = WORD_W - 1 - 8 * i;
    logic in_win;
    assign in_win = (SUM_W'(i) >= win_lo) && (SUM_W'(i) < win_hi);
    assign merged[TOP -: 8] = in_win ? aligned_chunk[TOP -: 8]
                                     : mem_word[TOP -: 8];
  end

endmodule

// File: rtl/pik_state.sv
// Holds the key register and the read offset.
module pik_state #(
  parameter  int unsigned WORD_BYTES = 8,
  parameter  int unsigned KEY_BYTES  = 32,
  parameter  int unsigned LEN_W      = 64,
  localparam int unsigned CNT_W      = $clog2(WORD_BYTES + 1),
  localparam int unsigned WORD_W     = 8 * WORD_BYTES,
  localparam int unsigned KEY_W      = 8 * KEY_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              is_read,
  input  logic              refused,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] gathered,
  output logic [KEY_W-1:0]  key_q,
  output logic [LEN_W-1:0]  off_q
);

  logic [WORD_W-1:0] tail;
  logic [KEY_W-1:0]  key_next;

  // keep only the 'count' leading gathered bytes, right-justified
  assign tail     = gathered >> {CNT_W'(WORD_BYTES) - count, 3'b000};
  assign key_next = (key_q << {count, 3'b000}) | KEY_W'(tail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
      off_q <= '0;
    end else if (upd) begin
      if (!is_read) begin
        key_q <= key_next;
        off_q <= '0;
      end else if (!refused) begin
        off_q <= off_q + LEN_W'(count);
      end
    end
  end

  // R5
  wr_rewinds_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !is_read |=> off_q == '0);

  // R6
  rd_advances_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && is_read && !refused |=> off_q == $past(off_q) + LEN_W'($past(count)));

  // R6
  rd_keeps_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && is_read |=> $stable(key_q));

  // R7
  refused_holds_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && is_read && refused |=> $stable(off_q));

endmodule

// File: rtl/pik_unit.sv
// Top: request/result handshake around the clip, lane and state logic.
module pik_unit
  import pik_pkg::*;
#(
  parameter  int unsigned WORD_BYTES = PIK_WORD_BYTES,
  parameter  int unsigned KEY_BYTES  = PIK_KEY_BYTES,
  parameter  int unsigned LEN_W      = PIK_LEN_W,
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES),
  localparam int unsigned CNT_W      = $clog2(WORD_BYTES + 1),
  localparam int unsigned WORD_W     = 8 * WORD_BYTES,
  localparam int unsigned KEY_W      = 8 * KEY_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_read,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [LEN_W-1:0]  req_count,
  input  logic [WORD_W-1:0] req_mem_word,
  input  logic [WORD_W-1:0] req_chunk,
  input  logic [LEN_W-1:0]  req_data_len,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CNT_W-1:0]  rsp_count,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_error,
  output logic [KEY_W-1:0]  key,
  output logic [LEN_W-1:0]  offset
);

  xfer_dir_e         dir;
  logic              take;
  logic [CNT_W-1:0]  eff;
  logic              refused;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] gathered;

  assign dir       = xfer_dir_e'(req_is_read);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  pik_clip #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_clip (
    .lane       (req_lane),
    .req_count  (req_count),
    .is_read    (req_is_read),
    .cur_offset (offset),
    .data_len   (req_data_len),
    .eff        (eff),
    .overrun    (refused)
  );

  pik_lanes #(.WORD_BYTES(WORD_BYTES)) u_lanes (
    .lane     (req_lane),
    .count    (eff),
    .mem_word (req_mem_word),
    .chunk    (req_chunk),
    .merged   (merged),
    .gathered (gathered)
  );

  pik_state #(.WORD_BYTES(WORD_BYTES), .KEY_BYTES(KEY_BYTES), .LEN_W(LEN_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (take),
    .is_read  (req_is_read),
    .refused  (refused),
    .count    (eff),
    .gathered (gathered),
    .key_q    (key),
    .off_q    (offset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_count <= '0;
      rsp_word  <= '0;
      rsp_error <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_count <= eff;
      rsp_word  <= (dir == XFER_TO_MEM && !refused) ? merged : req_mem_word;
      rsp_error <= refused;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_word)
                                && $stable(rsp_count) && $stable(rsp_error));

  // R1
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_count <= CNT_W'(WORD_BYTES));

  // R2
  window_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (LEN_W'($past(req_lane)) + LEN_W'(rsp_count)) <= LEN_W'(WORD_BYTES));

  // R7
  refuse_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_is_read && (offset > req_data_len) |=> rsp_error && rsp_count == '0);

  // R5
  write_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_is_read |=> !rsp_error && rsp_word == $past(req_mem_word));

  // R10
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

endmodule

// File: tb/test_pik_unit.sv
module test_pik_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_is_read = 1'b0;
  logic [2:0]   req_lane = '0;
  logic [63:0]  req_count = '0;
  logic [63:0]  req_mem_word = '0;
  logic [63:0]  req_chunk = '0;
  logic [63:0]  req_data_len = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [3:0]   rsp_count;
  logic [63:0]  rsp_word;
  logic         rsp_error;
  logic [255:0] key;
  logic [63:0]  offset;

  always #10 clk = ~clk;   // 50 MHz

  pik_unit i_pik_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_read(req_is_read),
    .req_lane(req_lane), .req_count(req_count), .req_mem_word(req_mem_word),
    .req_chunk(req_chunk), .req_data_len(req_data_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_count(rsp_count),
    .rsp_word(rsp_word), .rsp_error(rsp_error), .key(key), .offset(offset)
  );

  typedef struct {
    logic [3:0]  cnt;
    logic [63:0] word;
    logic        err;
    string       tag;
  } exp_t;

  exp_t         sb[$];
  int           errors = 0;
  int           checks = 0;
  bit           drain = 1'b0;
  bit           done = 1'b0;
  logic [7:0]   lfsr = 8'hA5;
  logic [255:0] m_key = '0;
  logic [63:0]  m_off = '0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // consumer back-pressure pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = drain ? 1'b1 : (lfsr[0] | lfsr[2]);
  end

  // monitor: compare each result as it is taken
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected result", 256'(rsp_word), 256'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_count == e.cnt, {e.tag, " count R1 R2 R3"}, 256'(rsp_count), 256'(e.cnt));
        chk(rsp_word == e.word, {e.tag, " word R8"}, 256'(rsp_word), 256'(e.word));
        chk(rsp_error == e.err, {e.tag, " error R7"}, 256'(rsp_error), 256'(e.err));
      end
    end
  end

  // driver: computes the expected outcome, drives one request, checks state
  task automatic xfer(input bit rd, input logic [2:0] lane, input logic [63:0] cnt,
                      input logic [63:0] mem, input logic [63:0] chunk,
                      input logic [63:0] len, input string tag);
    exp_t e;
    int   n;
    bit   bad;
    n = (cnt > 64'd8) ? 8 : int'(cnt);
    if (n > 8 - int'(lane)) n = 8 - int'(lane);
    bad = rd && (m_off > len);
    if (bad) n = 0;
    else if (rd && (len - m_off) < 64'(n)) n = int'(len - m_off);
    e.cnt = 4'(n);
    e.err = bad;
    e.tag = tag;
    e.word = mem;
    if (rd && !bad) begin
      for (int k = 0; k < n; k++)
        e.word[63 - 8*(int'(lane) + k) -: 8] = chunk[63 - 8*k -: 8];
      m_off = m_off + 64'(n);
    end
    if (!rd) begin
      for (int k = 0; k < n; k++)
        m_key = {m_key[247:0], mem[63 - 8*(int'(lane) + k) -: 8]};
      m_off = '0;
    end
    req_is_read  = rd;
    req_lane     = lane;
    req_count    = cnt;
    req_mem_word = mem;
    req_chunk    = chunk;
    req_data_len = len;
    req_valid    = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(key == m_key, {tag, " key R4 R6"}, key, m_key);
    chk(offset == m_off, {tag, " offset R5 R6 R7"}, 256'(offset), 256'(m_off));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(key == '0, "R10 key", key, '0);
    chk(offset == '0, "R10 offset", 256'(offset), '0);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", 256'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 aligned 3-byte write moves exactly 3
    xfer(1'b0, 3'd0, 64'd3, 64'h1122334455667788, '0, '0, "R2 aligned3");
    // R2 misaligned clip to 2, R4 append
    xfer(1'b0, 3'd6, 64'd5, 64'h1122334455667788, '0, '0, "R2 lane6");
    // R1 oversize request
    xfer(1'b0, 3'd0, 64'd20, 64'hA0A1A2A3A4A5A6A7, '0, '0, "R1 big");
    xfer(1'b0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hB0B1B2B3B4B5B6B7, '0, '0, "R1 huge");
    xfer(1'b0, 3'd0, 64'd8, 64'hC0C1C2C3C4C5C6C7, '0, '0, "R4 fill");
    xfer(1'b0, 3'd0, 64'd8, 64'hD0D1D2D3D4D5D6D7, '0, '0, "R4 overflow");

    // reads: R8 merge, R6 advance, R3 remaining limit
    xfer(1'b1, 3'd3, 64'd3, 64'h1111111111111111, 64'hC0C1C2C3C4C5C6C7, 64'd20, "R8 lane3");
    xfer(1'b1, 3'd0, 64'd100, 64'h2222222222222222, 64'h0102030405060708, 64'd20, "R1 read big");
    xfer(1'b1, 3'd5, 64'd8, 64'h3333333333333333, 64'hE0E1E2E3E4E5E6E7, 64'd20, "R2 read lane5");
    xfer(1'b1, 3'd0, 64'd8, 64'h4444444444444444, 64'hF0F1F2F3F4F5F6F7, 64'd20, "R3 remain6");
    xfer(1'b1, 3'd1, 64'd4, 64'h5555555555555555, 64'h9999999999999999, 64'd20, "R7 at end ok");
    xfer(1'b1, 3'd0, 64'd4, 64'h6666666666666666, 64'h9999999999999999, 64'd19, "R7 refuse");
    xfer(1'b1, 3'd2, 64'd0, 64'h7777777777777777, 64'h9999999999999999, 64'd100, "R3 zero count");
    // R5 write rewinds offset
    xfer(1'b0, 3'd7, 64'd1, 64'h00000000000000EE, '0, '0, "R5 rewind");

    // R9 back-to-back mix under random back-pressure
    for (int i = 0; i < 40; i++) begin
      logic [63:0] v;
      v = 64'h9E3779B97F4A7C15 * 64'(i + 1);
      xfer(v[3], v[10:8], {60'd0, v[15:12]}, v ^ 64'h5A5A5A5A5A5A5A5A, v,
           64'(v[21:16]) , "R9 stream");
    end

    drain = 1'b1;
    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R9 all results drained", 256'(sb.size()), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule